// File: doc/BRIEF.md
# Parallel EPROM Mode-Decoding Model

This block is a synthesizable, clocked stand-in for a byte-wide parallel EPROM. It serves as the device under test for a programmer design. The data bus is split into an input, an output and an output-enable, and the voltage-sensitive pins are plain flags: one says the programming supply is present, and one says the high-voltage level is applied to address line 9. From chip enable, output enable, the program strobe and these flags, the block decodes seven modes: standby, program inhibit, read, output disable, program, program verify and identifier (signature) readout.

The array holds words that start with every bit at 1. A program pulse can only clear bits, because it stores the old word ANDed with the bus data. A bulk-erase input returns the whole array to the blank value in one clock. Output data appears a parameterised number of cycles after the drive conditions are met, which models the access delay. The identifier bytes replace array data while the high-voltage flag is set. Timing, voltages and supply current are not modelled. All pins are sampled on the rising clock edge.

Top module: `eprom_mode_model`

## Requirements
- R1: With `vpp_hi` low, `ce_n` low, `oe_n` low and `a9_hv` low (read mode), and once the delay of R10 has passed, `dq_oe` is 1 and `dq_out` shows the word at the address sampled at the previous clock edge. `oe_n` high with `ce_n` low (output disable) keeps `dq_oe` at 0.
- R2: Whenever `ce_n` is sampled high (standby, or program inhibit when `vpp_hi` is 1), `dq_oe` is 0 after that edge, whatever `oe_n` is.
- R3: After reset, every word reads FFh, and `dq_oe` and `dq_out` are 0.
- R4: With `vpp_hi` 1 and `ce_n` low, a falling edge of `pgm_n` causes exactly one write. The write uses the address and `dq_in` sampled at the edge where `pgm_n` is first seen low, and stores the old word AND `dq_in`.
- R5: Programming never turns a 0 bit into a 1. A repeated pulse with the same data leaves the word unchanged.
- R6: A `pgm_n` pulse while `ce_n` is high writes nothing, even with `vpp_hi` at 1.
- R7: With `vpp_hi` 0, `a9_hv` 1, and `ce_n` and `oe_n` low, the output is 20h when address bit 0 is 0 and 05h when it is 1, regardless of array content.
- R8: With `vpp_hi` 1, `pgm_n` high, and `ce_n` and `oe_n` low (verify), the addressed array word is driven.
- R9: While `vpp_hi` is 1, `ce_n` is low and `pgm_n` is low, `dq_oe` stays 0 even with `oe_n` low.
- R10: `dq_oe` rises at the OE_DELAY-th consecutive clock edge that samples a driving mode (R1, R7, R8). It falls at the first edge that samples a non-driving mode. Whenever `dq_oe` is 0, `dq_out` is 00h.
- R11: `erase` sampled high returns every word to FFh in one edge and cancels a write that is pending at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; blanks the array |
| ce_n | input | 1 | Chip enable, active low (device select) |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage present on address line 9 (identifier mode) |
| erase | input | 1 | Bulk erase to FFh |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Data bus, input side |
| dq_out | output | DATA_W | Data bus, output side |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with ADDR_W = 4 and OE_DELAY = 3. A 16-word array lets every word be blanked, programmed twice and read back in a short run. A three-cycle delay shows the output staying undriven for two edges and then rising, and shows a single non-driving edge restarting the count. A reference model checks every cycle, including edges where programming, erase and reads meet.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_READ,
    MD_OUT_OFF,
    MD_PROGRAM,
    MD_VERIFY,
    MD_SIGNATURE
  } eprom_mode_e;

  localparam int WORD_BITS = 8;

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        pgm_n,
  input  logic        vpp_hi,
  input  logic        a9_hv,
  output eprom_mode_e mode,
  output logic        drive,
  output logic        sig_sel
);

  // Chip enable dominates, then the supply flag, then the output enable.
  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_hi) begin
      if (!pgm_n)     mode = MD_PROGRAM;
      else if (!oe_n) mode = MD_VERIFY;
      else            mode = MD_OUT_OFF;
    end else if (oe_n) begin
      mode = MD_OUT_OFF;
    end else if (a9_hv) begin
      mode = MD_SIGNATURE;
    end else begin
      mode = MD_READ;
    end
  end

  always_comb begin
    drive   = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_SIGNATURE);
    sig_sel = (mode == MD_SIGNATURE);
  end

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_used
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  used;
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              wr_go;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] new_word;

  // The read register holds the word of wr_addr_q, captured at the
  // edge where the pulse was detected.
  always_comb begin
    wr_go    = wr_pend && !erase;
    old_word = rd_used ? rd_data : {DATA_W{1'b1}};
    new_word = old_word & wr_data_q;
  end

  // Data storage: one read port, one write port, read-first; no reset.
  always_ff @(posedge clk) begin
    rd_data <= mem[addr];
    if (wr_go) mem[wr_addr_q] <= new_word;
  end

  // Per-word "written since erase" flags give a one-cycle bulk erase.
  always_ff @(posedge clk) begin
    if (rst || erase) begin
      used <= '0;
    end else if (wr_go) begin
      used[wr_addr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_used   <= 1'b0;
      wr_pend   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      rd_used <= used[addr];
      wr_pend <= wr_start && !erase;
      if (wr_start) begin
        wr_addr_q <= addr;
        wr_data_q <= din;
      end
    end
  end

  assert_erase_blank_R11: assert property (@(posedge clk) disable iff (rst)
    $past(erase) |-> (used == '0));

  assert_one_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> !wr_pend);

  assert_clear_only_R5: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> ((rd_data & ~$past(old_word)) == '0) || ($past(addr) != $past(wr_addr_q))
              || !$past(rd_used));

endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage #(
  parameter int              DATA_W   = 8,
  parameter int              OE_DELAY = 2,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h20,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive,
  input  logic              sig_sel,
  input  logic              a0,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_used,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int              CW   = $clog2(OE_DELAY + 1);
  localparam logic [CW-1:0]   LAST = CW'(OE_DELAY - 1);

  logic [CW-1:0] cnt;
  logic          oe_q;
  logic          sig_q;
  logic          a0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      oe_q  <= 1'b0;
      sig_q <= 1'b0;
      a0_q  <= 1'b0;
    end else begin
      if (!drive)           cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      oe_q  <= drive && (cnt == LAST);
      sig_q <= sig_sel;
      a0_q  <= a0;
    end
  end

  always_comb begin
    if (!oe_q)       dq_out = '0;
    else if (sig_q)  dq_out = a0_q ? DEV_ID : MFR_ID;
    else if (rd_used) dq_out = rd_data;
    else             dq_out = {DATA_W{1'b1}};
    dq_oe = oe_q;
  end

  assert_drive_gap_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(drive) |-> !dq_oe);

  assert_id_code_R7: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && sig_q) |-> (dq_out == MFR_ID || dq_out == DEV_ID));

endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = WORD_BITS,
  parameter int OE_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  eprom_mode_e       mode;
  logic              drive;
  logic              sig_sel;
  logic              pgm_q;
  logic              wr_start;
  logic [DATA_W-1:0] rd_data;
  logic              rd_used;

  eprom_mode_decode u_decode (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .a9_hv   (a9_hv),
    .mode    (mode),
    .drive   (drive),
    .sig_sel (sig_sel)
  );

  // Falling-edge detect on the strobe: one write per pulse.
  always_ff @(posedge clk) begin
    if (rst) pgm_q <= 1'b1;
    else     pgm_q <= pgm_n;
  end

  always_comb wr_start = (mode == MD_PROGRAM) && pgm_q;

  eprom_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .erase    (erase),
    .wr_start (wr_start),
    .addr     (addr),
    .din      (dq_in),
    .rd_data  (rd_data),
    .rd_used  (rd_used)
  );

  eprom_out_stage #(
    .DATA_W   (DATA_W),
    .OE_DELAY (OE_DELAY),
    .MFR_ID   (DATA_W'(8'h20)),
    .DEV_ID   (DATA_W'(8'h05))
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .drive   (drive),
    .sig_sel (sig_sel),
    .a0      (addr[0]),
    .rd_data (rd_data),
    .rd_used (rd_used),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n) |-> !dq_oe);

  assert_prog_hiz_R9: assert property (@(posedge clk) disable iff (rst)
    $past(vpp_hi && !ce_n && !pgm_n) |-> !dq_oe);

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_out == '0));

endmodule

// File: tb/eprom_mode_model_tb.sv
module eprom_mode_model_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int DLY  = 3;
  localparam int NW   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic          vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int    nchk = 0;
  int    nerr = 0;
  string cur_req = "R3";
  bit    live = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_mode_model #(.ADDR_W(AW), .DATA_W(DW), .OE_DELAY(DLY)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // Behavioural reference model, updated on every rising edge.
  logic [7:0] m_mem [NW];
  bit         m_set [NW];
  int         run;
  bit         pgm_prev, pend, drv, sg, start;
  int         pa;
  logic [7:0] pd, word;
  logic       exp_oe;
  logic [7:0] exp_out;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) m_set[i] = 1'b0;
      run = 0; pgm_prev = 1'b1; pend = 1'b0; exp_oe = 1'b0; exp_out = 8'h00;
    end else begin
      sg    = !ce_n && !vpp_hi && !oe_n && a9_hv;
      drv   = !ce_n && !oe_n && (vpp_hi ? pgm_n : 1'b1);
      run   = drv ? ((run < 1000) ? run + 1 : run) : 0;
      exp_oe = drv && (run >= DLY);
      word  = m_set[addr] ? m_mem[addr] : 8'hFF;
      exp_out = !exp_oe ? 8'h00 : (sg ? (addr[0] ? 8'h05 : 8'h20) : word);
      start = !ce_n && vpp_hi && !pgm_n && pgm_prev;
      if (erase) begin
        for (int i = 0; i < NW; i++) m_set[i] = 1'b0;
        pend = 1'b0;
      end else begin
        if (pend) begin
          m_mem[pa] = (m_set[pa] ? m_mem[pa] : 8'hFF) & pd;
          m_set[pa] = 1'b1;
        end
        pend = start;
        if (start) begin pa = int'(addr); pd = dq_in; end
      end
      pgm_prev = pgm_n;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (live) begin
      nchk++;
      if (dq_oe !== exp_oe || dq_out !== exp_out) begin
        nerr++;
        $display("FAIL %s (model): oe=%b out=%h expected oe=%b out=%h",
                 cur_req, dq_oe, dq_out, exp_oe, exp_out);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic eo, logic [7:0] ed);
    nchk++;
    if (dq_oe !== eo || dq_out !== ed) begin
      nerr++;
      $display("FAIL %s: oe=%b out=%h expected oe=%b out=%h", req, dq_oe, dq_out, eo, ed);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0; erase = 1'b0;
  endtask

  // Read one word; checks the delay window and the value.
  task automatic read_word(string req, logic [AW-1:0] a, logic [7:0] ev);
    cur_req = req;
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    tick(DLY - 1);
    chk("R10", 1'b0, 8'h00);
    tick(1);
    chk(req, 1'b1, ev);
    idle();
    tick(1);
  endtask

  task automatic program_word(logic [AW-1:0] a, logic [7:0] d);
    cur_req = "R4";
    addr = a; dq_in = d; vpp_hi = 1'b1; ce_n = 1'b0;
    tick(1);
    pgm_n = 1'b0;
    tick(3);
    pgm_n = 1'b1;
    tick(1);
    idle();
    tick(1);
  endtask

  initial begin
    idle();
    tick(3);
    rst = 1'b0;
    tick(1);
    live = 1'b1;
    chk("R3", 1'b0, 8'h00);
    read_word("R3", 4'd0, 8'hFF);
    read_word("R3", 4'd15, 8'hFF);

    // R4: program a blank word.
    program_word(4'd3, 8'hA5);
    read_word("R4", 4'd3, 8'hA5);
    // R5: second pulse ANDs, repeat leaves word unchanged.
    program_word(4'd3, 8'h3C);
    read_word("R5", 4'd3, 8'h24);
    program_word(4'd3, 8'h3C);
    read_word("R5", 4'd3, 8'h24);
    program_word(4'd3, 8'hFF);
    read_word("R5", 4'd3, 8'h24);

    // R6: pulse with chip enable high writes nothing.
    cur_req = "R6";
    addr = 4'd5; dq_in = 8'h00; vpp_hi = 1'b1; ce_n = 1'b1;
    tick(1); pgm_n = 1'b0; tick(3); pgm_n = 1'b1; tick(1);
    chk("R6", 1'b0, 8'h00);
    idle(); tick(1);
    read_word("R6", 4'd5, 8'hFF);

    // R8: verify with supply present drives the array word.
    cur_req = "R8";
    addr = 4'd3; vpp_hi = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    tick(DLY);
    chk("R8", 1'b1, 8'h24);
    // R9: strobe low with oe low: bus released, stays released.
    cur_req = "R9";
    dq_in = 8'hF0; pgm_n = 1'b0;
    tick(1); chk("R9", 1'b0, 8'h00);
    tick(2); chk("R9", 1'b0, 8'h00);
    pgm_n = 1'b1; idle(); tick(1);
    read_word("R9", 4'd3, 8'h20);

    // R7: identifier codes override the array (word 3 holds 20h now).
    cur_req = "R7";
    a9_hv = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = 4'd2;
    tick(DLY); chk("R7", 1'b1, 8'h20);
    addr = 4'd3; tick(1); chk("R7", 1'b1, 8'h05);
    addr = 4'd9; tick(1); chk("R7", 1'b1, 8'h05);
    // R2: standby releases the bus even with oe low.
    cur_req = "R2";
    ce_n = 1'b1; tick(1); chk("R2", 1'b0, 8'h00);
    tick(2); chk("R2", 1'b0, 8'h00);
    // R10: restart of the delay after one non-driving edge.
    cur_req = "R10";
    a9_hv = 1'b0; ce_n = 1'b0; addr = 4'd3;
    tick(1); chk("R10", 1'b0, 8'h00);
    tick(DLY - 1); chk("R10", 1'b1, 8'h20);
    // R1: output disable and address following.
    cur_req = "R1";
    addr = 4'd0; tick(1); chk("R1", 1'b1, 8'hFF);
    oe_n = 1'b1; tick(1); chk("R1", 1'b0, 8'h00);
    idle(); tick(1);

    // R11: bulk erase, and erase cancelling a pending write.
    program_word(4'd7, 8'h11);
    read_word("R11", 4'd7, 8'h11);
    cur_req = "R11";
    erase = 1'b1; tick(1); erase = 1'b0; tick(1);
    read_word("R11", 4'd7, 8'hFF);
    read_word("R11", 4'd3, 8'hFF);
    cur_req = "R11";
    addr = 4'd8; dq_in = 8'h00; vpp_hi = 1'b1; ce_n = 1'b0;
    tick(1); pgm_n = 1'b0; tick(1); erase = 1'b1; tick(1); erase = 1'b0;
    tick(1); pgm_n = 1'b1; idle(); tick(1);
    read_word("R11", 4'd8, 8'hFF);

    // Mixed traffic for the per-cycle model comparison.
    cur_req = "R4";
    for (int k = 0; k < NW; k++) program_word(AW'(k), 8'(k * 37 + 5));
    for (int k = 0; k < NW; k++) read_word("R1", AW'(k), 8'(k * 37 + 5));

    live = 1'b0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nerr++; nchk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule